// File: doc/BRIEF.md
# Masked Time-of-Day Alarm

This block compares the running time of day (minutes, hours and day of the week, all supplied as BCD) against three programmable alarm bytes. When they agree, it raises a sticky alarm flag and, if enabled, an active-low interrupt. Bit 7 of each alarm byte is a mask. A set mask removes that field from the comparison. With the day mask set the alarm repeats daily. With the day and hour masks set it repeats hourly. With all three masks set it repeats every minute.

The comparison is made once per minute boundary. The timebase reports this boundary by presenting hundredths = 0x99 while its seconds-wrap signal is high; the time inputs then already carry the minute that is about to begin. A small register port gives access to the three alarm bytes. Any read or write of one of them clears the flag and releases the interrupt, so the handler that reads the alarm setting also acknowledges the alarm.

Top module: `tod_alarm`

## Requirements
- R1: After reset, all three alarm bytes read 0x00, `alarm_flag` is 0 and `irq_n` is 1.
- R2: Register port addresses: 0 is the minute alarm (8 bits), 1 is the hour alarm (8 bits) and 2 is the day alarm. In the day alarm, bit 7 is the mask, bits 2:0 are the day, and bits 6:3 always read 0. Address 3 is not an alarm register and reads 0x00. A written value reads back from the same address on `bus_rdata` during a read.
- R3: Bit 7 of each alarm byte masks its own field. Comparison uses bits 6:0 of the minute and hour bytes against `now_min` and `now_hour`, and bits 2:0 of the day byte against `now_day`. With no mask set, the alarm fires only when all three fields match.
- R4: With only the day mask set, the alarm fires when both minutes and hours match, whatever the day.
- R5: With the day and hour masks set, the alarm fires whenever the minutes match.
- R6: With all three masks set, the alarm fires at every evaluation.
- R7: An evaluation happens only on the first clock where `now_hund` == 0x99 and `sec_wrap` == 1 both hold. Holding that condition for more cycles gives no further evaluation. If either half is absent, no evaluation happens.
- R8: The hour comparison covers all of bits 6:0, including the 12-hour select (bit 6) and the AM/PM bit (bit 5). An alarm for 11 PM does not fire at 11 AM.
- R9: The flag is set one clock after a matching evaluation, whatever the state of `irq_en`. Once set, it stays set until it is cleared. `irq_n` is 0 exactly when the flag is 1 and `irq_en` is 1.
- R10: A read or write (`bus_en` = 1) at address 0, 1 or 2 clears the flag on the next clock. An access at address 3 leaves the flag unchanged. A matching evaluation in the same cycle as a clearing access takes priority, and the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours: bit 6 selects 12-hour mode, bit 5 is PM or the twenty-hours digit, bits 4:0 are BCD |
| now_day | input | 3 | Current day of week |
| now_hund | input | 8 | Current hundredths of a second, BCD |
| sec_wrap | input | 1 | High while seconds are about to roll from 59 to 00 |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_en | input | 1 | Interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The main check sweeps all eight mask combinations against every combination of matching and mismatching minute, hour and day. Each mask therefore shows that it drops only its own field, and the unmasked case shows that a single mismatching field blocks the alarm. During the sweep the interrupt enable alternates, which separates the flag from the interrupt pin. Further patterns hold the evaluation condition for several cycles, supply only one half of that condition, compare a 12-hour PM alarm against the same hour in AM, and place a clearing access in the same cycle as a match. Together these isolate edge detection, the timing qualifier, the AM/PM comparison and the clear priority.

// File: rtl/tod_alarm.sv
module tod_alarm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] now_min,
  input  logic [6:0] now_hour,
  input  logic [2:0] now_day,
  input  logic [7:0] now_hund,
  input  logic       sec_wrap,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_en,
  output logic       alarm_flag,
  output logic       irq_n
);

  logic [7:0] alm_min, alm_hour;
  logic       day_mask;
  logic [2:0] alm_day;
  logic       strobe_q;

  wire strobe  = (now_hund == 8'h99) && sec_wrap;
  wire eval    = strobe && !strobe_q;
  wire bus_hit = bus_en && (bus_addr != 2'd3);

  wire min_ok  = alm_min[7]  || (alm_min[6:0]  == now_min);
  wire hour_ok = alm_hour[7] || (alm_hour[6:0] == now_hour);
  wire day_ok  = day_mask    || (alm_day       == now_day);
  wire match   = min_ok && hour_ok && day_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_min  <= 8'h00;
      alm_hour <= 8'h00;
      day_mask <= 1'b0;
      alm_day  <= 3'd0;
    end else if (bus_en && bus_we) begin
      case (bus_addr)
        2'd0: alm_min  <= bus_wdata;
        2'd1: alm_hour <= bus_wdata;
        2'd2: begin
          day_mask <= bus_wdata[7];
          alm_day  <= bus_wdata[2:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (eval && match)
        alarm_flag <= 1'b1;
      else if (bus_hit)
        alarm_flag <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = alm_min;
      2'd1:    bus_rdata = alm_hour;
      2'd2:    bus_rdata = {day_mask, 4'b0000, alm_day};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_n = !(alarm_flag && irq_en);

  a_r10_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hit && !(eval && match)) |=> !alarm_flag);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !bus_hit) |=> alarm_flag);
  a_r7_set_only_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !eval) |=> !alarm_flag);
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_n);
  a_r2_day_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata[6:3] == 4'b0000));
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/test_tod_alarm.sv
`timescale 1ns/1ps
module test_tod_alarm;
  logic clk = 0, rst_n = 0;
  logic [6:0] now_min = 0, now_hour = 0;
  logic [2:0] now_day = 0;
  logic [7:0] now_hund = 0;
  logic sec_wrap = 0, bus_en = 0, bus_we = 0, irq_en = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic alarm_flag, irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tod_alarm i_tod_alarm (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic fire(logic [6:0] m, logic [6:0] h, logic [2:0] dy);
    @(negedge clk);
    now_min = m; now_hour = h; now_day = dy; now_hund = 8'h99; sec_wrap = 1;
    @(negedge clk);
    now_hund = 8'h00; sec_wrap = 0;
    #1;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 flag", {7'b0, alarm_flag}, 8'h00);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], d);
      chk("R1 reg", d, 8'h00);
    end

    // R2 register map and readback
    wr(0, 8'hA5); rd(0, d); chk("R2 min", d, 8'hA5);
    wr(1, 8'h7E); rd(1, d); chk("R2 hour", d, 8'h7E);
    wr(2, 8'hFB); rd(2, d); chk("R2 day bits 6:3 zero", d, 8'h83);
    wr(3, 8'hFF); rd(3, d); chk("R2 addr3", d, 8'h00);

    // R3 R4 R5 R6 R9 R10: sweep all masks over match/mismatch patterns
    for (int m = 0; m < 8; m++) begin
      for (int t = 0; t < 8; t++) begin
        logic exp_f;
        logic [6:0] cm, ch;
        logic [2:0] cd;
        wr(0, {m[0], 7'h30});
        wr(1, {m[1], 7'h10});
        wr(2, {m[2], 4'b0, 3'd3});
        cm = t[0] ? 7'h31 : 7'h30;
        ch = t[1] ? 7'h11 : 7'h10;
        cd = t[2] ? 3'd4 : 3'd3;
        irq_en = m[0] ^ t[0];
        exp_f = (m[0] || !t[0]) && (m[1] || !t[1]) && (m[2] || !t[2]);
        fire(cm, ch, cd);
        if (m == 0) chk("R3 no mask", {7'b0, alarm_flag}, {7'b0, exp_f});
        else if (m == 4) chk("R4 daily", {7'b0, alarm_flag}, {7'b0, exp_f});
        else if (m == 6) chk("R5 hourly", {7'b0, alarm_flag}, {7'b0, exp_f});
        else if (m == 7) chk("R6 every minute", {7'b0, alarm_flag}, {7'b0, exp_f});
        else chk("R3 per-field mask", {7'b0, alarm_flag}, {7'b0, exp_f});
        chk("R9 irq_n", {7'b0, irq_n}, {7'b0, !(exp_f && irq_en)});
        rd(m % 3, d);
        #1 chk("R10 read clears", {7'b0, alarm_flag}, 8'h00);
      end
    end
    irq_en = 1;

    // R7 qualifier halves
    wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80);
    @(negedge clk); now_hund = 8'h98; sec_wrap = 1;
    @(negedge clk); sec_wrap = 0; #1;
    chk("R7 hund not 99", {7'b0, alarm_flag}, 8'h00);
    @(negedge clk); now_hund = 8'h99; sec_wrap = 0;
    @(negedge clk); now_hund = 8'h00; #1;
    chk("R7 no sec wrap", {7'b0, alarm_flag}, 8'h00);

    // R7 held condition evaluates once
    @(negedge clk); now_hund = 8'h99; sec_wrap = 1;
    @(negedge clk); #1 chk("R7 first eval", {7'b0, alarm_flag}, 8'h01);
    bus_en = 1; bus_we = 0; bus_addr = 0;
    @(negedge clk); bus_en = 0;
    @(negedge clk); #1 chk("R7 held gives no re-eval", {7'b0, alarm_flag}, 8'h00);
    now_hund = 8'h00; sec_wrap = 0;

    // R9 flag sets with irq disabled, stays set
    irq_en = 0;
    fire(7'h00, 7'h00, 3'd1);
    chk("R9 flag set irq off", {7'b0, alarm_flag}, 8'h01);
    chk("R9 irq_n held high", {7'b0, irq_n}, 8'h01);
    repeat (4) @(negedge clk);
    #1 chk("R9 flag sticky", {7'b0, alarm_flag}, 8'h01);
    irq_en = 1; #1;
    chk("R9 irq_n asserts", {7'b0, irq_n}, 8'h00);

    // R10 address 3 does not clear; write clears
    rd(3, d); #1 chk("R10 addr3 read keeps", {7'b0, alarm_flag}, 8'h01);
    wr(3, 8'h55); #1 chk("R10 addr3 write keeps", {7'b0, alarm_flag}, 8'h01);
    wr(2, 8'h80); #1 chk("R10 write clears", {7'b0, alarm_flag}, 8'h00);
    chk("R10 irq released", {7'b0, irq_n}, 8'h01);

    // R10 match beats same-cycle clear
    @(negedge clk);
    now_hund = 8'h99; sec_wrap = 1; bus_en = 1; bus_we = 0; bus_addr = 1;
    @(negedge clk); bus_en = 0; now_hund = 8'h00; sec_wrap = 0; #1;
    chk("R10 match wins", {7'b0, alarm_flag}, 8'h01);
    rd(0, d);

    // R8 12-hour AM/PM
    wr(0, 8'h15); wr(1, 8'h71); wr(2, 8'h80);
    fire(7'h15, 7'h51, 3'd2);
    chk("R8 11AM vs 11PM alarm", {7'b0, alarm_flag}, 8'h00);
    fire(7'h15, 7'h71, 3'd2);
    chk("R8 11PM matches", {7'b0, alarm_flag}, 8'h01);
    rd(1, d);
    fire(7'h15, 7'h11, 3'd2);
    chk("R8 24h 11 vs 12h alarm", {7'b0, alarm_flag}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule